// File: doc/BRIEF.md
# Voice PCM serial port

This block is the digital serial side of a single-channel voice codec. A bit clock and two independent 8 kHz frame syncs arrive from the line side. On the receive path, each rising edge of the receive sync marks the most significant bit of a new 8-bit sample. Bits are taken on the falling edges of the bit clock, and the finished byte is handed out in parallel with a one-cycle valid strobe. On the transmit path, a rising edge of the transmit sync captures a parallel 8-bit code. That code is then driven out MSB first, one bit per rising bit-clock edge, with an output enable that marks the 8-bit slot.

All line signals are brought into a free-running system clock domain through two flip-flop stages. The system clock must run at least four times faster than the fastest bit clock, which is 2048 kHz. Bit-clock rates from 64 kHz to 2048 kHz and sync rates from 6 kHz to 10 kHz are covered. Two idle timers watch the bit clock and the transmit sync. If either one stops toggling for longer than its programmed limit, the block raises a power-save request and holds both paths idle until that signal moves again. Samples are raw 8-bit codes: companding, filtering and conversion belong to neighbouring blocks.

Top module: `pcm_voice_port`

## Requirements
- R1: While reset is low and after it is released, `rx_sample_o` is 0 and `rx_valid_o`, `tx_oe_o`, `tx_data_o` and `pwr_save_o` are 0 until line activity changes them.
- R2: After a rising edge of `rx_sync_i`, the next eight falling edges of `bclk_i` sample `rx_data_i` MSB first. On the eighth, `rx_sample_o` takes the assembled byte and `rx_valid_o` is high for exactly one system clock.
- R3: `rx_sample_o` changes only in a cycle where `rx_valid_o` is high, and holds its value otherwise.
- R4: A rising edge of `rx_sync_i` before eight bits are collected restarts the count. The partial byte is dropped and produces no strobe.
- R5: A rising edge of `tx_sync_i` raises `tx_oe_o` and puts bit 7 of the captured word on `tx_data_o`. Each later rising edge of `bclk_i` presents the next lower bit. The eighth such edge after the sync drops `tx_oe_o`.
- R6: While `tx_oe_o` is low, `tx_data_o` is 0.
- R7: When no edge of `bclk_i` is seen for `BCLK_TIMEOUT` system clocks, `pwr_save_o` goes high.
- R8: When no edge of `tx_sync_i` is seen for `FSYNC_TIMEOUT` system clocks, `pwr_save_o` goes high.
- R9: `pwr_save_o` falls as soon as the stopped signal shows an edge again, and both paths then frame normally on the next sync edge.
- R10: While `pwr_save_o` is high, no receive strobe is issued, `tx_oe_o` stays low, and any frame in progress is abandoned. A sync edge seen in that state is ignored.
- R11: Every output reacts on the third rising system clock edge after the line input change that causes it: two synchronizer stages, then one register.
- R12: Falling bit-clock edges after the eighth bit of a frame, and before the next receive sync, are ignored.
- R13: `tx_sample_i` is captured only in the cycle where the transmit sync edge is detected. Changing it during the slot does not alter the bits being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock, at least 4x the bit clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock (asynchronous to clk_i) |
| rx_sync_i | input | 1 | Receive frame sync; rising edge marks the MSB |
| rx_data_i | input | 1 | Serial receive data |
| tx_sync_i | input | 1 | Transmit frame sync; rising edge starts the slot |
| tx_sample_i | input | SAMPLE_W | Parallel code to be sent in the next slot |
| rx_sample_o | output | SAMPLE_W | Last complete received byte |
| rx_valid_o | output | 1 | One-cycle strobe when rx_sample_o is updated |
| tx_data_o | output | 1 | Serial transmit data |
| tx_oe_o | output | 1 | High during the 8-bit transmit slot |
| pwr_save_o | output | 1 | Power-save request: bit clock or transmit sync stopped |

## Verification
Each result lands on the third rising system clock edge after the line edge that causes it. Inputs are driven on falling system clock edges and outputs are read on falling edges. The behavioural reference in the bench delays its copies of the line inputs by the same three edges and compares all five outputs every cycle. The directed reads follow the same timing. The bit clock spends four system clocks in each phase, so a transmit bit is read just before the bit clock falls, three edges after its rise. The receive byte and strobe count are read after the frame ends. Power-save is read after the stopped interval has run past its limit and again after the signal returns.

// File: rtl/pcm_port_pkg.sv
// Shared definitions for the voice PCM serial port.
// Assumes: nothing beyond IEEE 1800-2017.
package pcm_port_pkg;

    // Frame engine state, shared by the receive and transmit engines.
    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_RUN  = 1'b1
    } pcm_eng_e;

    // Width of a bit counter able to index SAMPLE_W bits.
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pcm_in_sync.sv
// Brings one asynchronous line signal into clk_i and flags its edges.
// Assumes: the input holds each level for at least 2 system clocks.
// level_o is the synchronized value; rise_o/fall_o are one-cycle pulses.
module pcm_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    // STAGES synchronizer flops plus one history flop for edge detection.
    logic [STAGES:0] pipe_q;

    // Shift the line value through the synchronizer chain.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[STAGES-1:0], d_i};
        end
    end

    assign level_o = pipe_q[STAGES-1];
    assign rise_o  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign fall_o  = ~pipe_q[STAGES-1] & pipe_q[STAGES];

endmodule

// File: rtl/pcm_idle_timer.sv
// Counts system clocks since the last activity pulse; reports expiry.
// Assumes: LIMIT >= 1. The count saturates at LIMIT and expired_o stays high
// until the next activity pulse clears it.
module pcm_idle_timer #(
    parameter int LIMIT = 4096
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic activity_i,
    output logic expired_o
);
    localparam int TW = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] LIM = TW'(LIMIT);

    logic [TW-1:0] cnt_q;

    // Restart on activity, otherwise count up to the saturating limit.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (activity_i) begin
            cnt_q <= '0;
        end else if (cnt_q != LIM) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = (cnt_q == LIM);

endmodule

// File: rtl/pcm_rx_deser.sv
// Receive engine: collects SAMPLE_W bits MSB first after a sync rising edge.
// Assumes: inputs are already synchronized pulses in clk_i. A sync edge has
// priority over a bit edge in the same cycle. hold_i abandons any frame.
module pcm_rx_deser
    import pcm_port_pkg::*;
#(
    parameter int SAMPLE_W = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                hold_i,
    input  logic                sync_rise_i,
    input  logic                bclk_fall_i,
    input  logic                data_i,
    output logic [SAMPLE_W-1:0] sample_o,
    output logic                valid_o
);
    localparam int CW = cnt_width(SAMPLE_W);
    localparam logic [CW-1:0] LAST = CW'(SAMPLE_W - 1);

    pcm_eng_e            state_q;
    logic [CW-1:0]       cnt_q;
    logic [SAMPLE_W-1:0] shift_q;
    logic [SAMPLE_W-1:0] next_shift;

    assign next_shift = {shift_q[SAMPLE_W-2:0], data_i};

    // Frame control, bit collection and hand-over of the finished byte.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q  <= ENG_IDLE;
            cnt_q    <= '0;
            shift_q  <= '0;
            sample_o <= '0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (hold_i) begin
                state_q <= ENG_IDLE;
            end else if (sync_rise_i) begin
                state_q <= ENG_RUN;
                cnt_q   <= '0;
            end else if ((state_q == ENG_RUN) && bclk_fall_i) begin
                shift_q <= next_shift;
                if (cnt_q == LAST) begin
                    sample_o <= next_shift;
                    valid_o  <= 1'b1;
                    state_q  <= ENG_IDLE;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pcm_tx_ser.sv
// Transmit engine: captures a word on a sync rising edge and sends it MSB
// first, advancing one bit per bit-clock rising edge.
// Assumes: synchronized pulses in clk_i; sync edge wins over a bit edge.
// data_o is forced low outside the slot.
module pcm_tx_ser
    import pcm_port_pkg::*;
#(
    parameter int SAMPLE_W = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                hold_i,
    input  logic                sync_rise_i,
    input  logic                bclk_rise_i,
    input  logic [SAMPLE_W-1:0] word_i,
    output logic                data_o,
    output logic                oe_o
);
    localparam int CW = cnt_width(SAMPLE_W);
    localparam logic [CW-1:0] LAST = CW'(SAMPLE_W - 1);

    pcm_eng_e            state_q;
    logic [CW-1:0]       cnt_q;
    logic [SAMPLE_W-1:0] shift_q;

    // Slot control: load on sync, shift on each bit-clock rise, stop after the last bit.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ENG_IDLE;
            cnt_q   <= '0;
            shift_q <= '0;
        end else if (hold_i) begin
            state_q <= ENG_IDLE;
        end else if (sync_rise_i) begin
            state_q <= ENG_RUN;
            cnt_q   <= '0;
            shift_q <= word_i;
        end else if ((state_q == ENG_RUN) && bclk_rise_i) begin
            if (cnt_q == LAST) begin
                state_q <= ENG_IDLE;
            end else begin
                cnt_q   <= cnt_q + 1'b1;
                shift_q <= {shift_q[SAMPLE_W-2:0], 1'b0};
            end
        end
    end

    assign oe_o   = (state_q == ENG_RUN);
    assign data_o = oe_o & shift_q[SAMPLE_W-1];

endmodule

// File: rtl/pcm_voice_port.sv
// Voice PCM serial port, top level.
// Synchronizes the line signals, runs the receive and transmit engines,
// and raises a power-save request when the bit clock or the transmit sync
// stops. Assumes clk_i >= 4x bit clock. The default timeouts suit a
// 250 MHz clk_i: about 16 us for the bit clock and about 167 us for the
// transmit sync, which is one frame at 6 kHz.
module pcm_voice_port #(
    parameter int SAMPLE_W      = 8,
    parameter int SYNC_STAGES   = 2,
    parameter int BCLK_TIMEOUT  = 4096,
    parameter int FSYNC_TIMEOUT = 41750
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                bclk_i,
    input  logic                rx_sync_i,
    input  logic                rx_data_i,
    input  logic                tx_sync_i,
    input  logic [SAMPLE_W-1:0] tx_sample_i,
    output logic [SAMPLE_W-1:0] rx_sample_o,
    output logic                rx_valid_o,
    output logic                tx_data_o,
    output logic                tx_oe_o,
    output logic                pwr_save_o
);
    logic bclk_lvl, bclk_rise, bclk_fall;
    logic rxs_lvl, rxs_rise, rxs_fall;
    logic txs_lvl, txs_rise, txs_fall;
    logic dat_lvl, dat_rise, dat_fall;
    logic bclk_idle, fsync_idle;

    pcm_in_sync #(.STAGES(SYNC_STAGES)) u_sync_bclk (
        .clk_i(clk_i), .rst_ni(rst_ni), .d_i(bclk_i),
        .level_o(bclk_lvl), .rise_o(bclk_rise), .fall_o(bclk_fall)
    );
    pcm_in_sync #(.STAGES(SYNC_STAGES)) u_sync_rxs (
        .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rx_sync_i),
        .level_o(rxs_lvl), .rise_o(rxs_rise), .fall_o(rxs_fall)
    );
    pcm_in_sync #(.STAGES(SYNC_STAGES)) u_sync_txs (
        .clk_i(clk_i), .rst_ni(rst_ni), .d_i(tx_sync_i),
        .level_o(txs_lvl), .rise_o(txs_rise), .fall_o(txs_fall)
    );
    pcm_in_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
        .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rx_data_i),
        .level_o(dat_lvl), .rise_o(dat_rise), .fall_o(dat_fall)
    );

    // Edge flags not needed by any engine, kept visible as one sink.
    logic unused_edges;
    assign unused_edges = ^{bclk_lvl, rxs_lvl, rxs_fall, txs_lvl, dat_rise, dat_fall};

    pcm_idle_timer #(.LIMIT(BCLK_TIMEOUT)) u_bclk_timer (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .activity_i(bclk_rise | bclk_fall), .expired_o(bclk_idle)
    );
    pcm_idle_timer #(.LIMIT(FSYNC_TIMEOUT)) u_fsync_timer (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .activity_i(txs_rise | txs_fall), .expired_o(fsync_idle)
    );

    assign pwr_save_o = bclk_idle | fsync_idle;

    pcm_rx_deser #(.SAMPLE_W(SAMPLE_W)) u_rx (
        .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(pwr_save_o),
        .sync_rise_i(rxs_rise), .bclk_fall_i(bclk_fall), .data_i(dat_lvl),
        .sample_o(rx_sample_o), .valid_o(rx_valid_o)
    );

    pcm_tx_ser #(.SAMPLE_W(SAMPLE_W)) u_tx (
        .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(pwr_save_o),
        .sync_rise_i(txs_rise), .bclk_rise_i(bclk_rise), .word_i(tx_sample_i),
        .data_o(tx_data_o), .oe_o(tx_oe_o)
    );

endmodule

// File: rtl/pcm_voice_port_chk.sv
// Property checker for pcm_voice_port, attached with bind below.
module pcm_voice_port_chk #(
    parameter int SAMPLE_W = 8
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic [SAMPLE_W-1:0] rx_sample_o,
    input logic                rx_valid_o,
    input logic                tx_data_o,
    input logic                tx_oe_o,
    input logic                pwr_save_o
);
    // R2: the receive strobe is a single-cycle pulse.
    p_valid_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_valid_o |=> !rx_valid_o);

    // R3: the receive byte only moves together with its strobe.
    p_sample_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rx_valid_o |-> $stable(rx_sample_o));

    // R5: a transmit slot lasts longer than one system clock.
    p_slot_open_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(tx_oe_o) |=> tx_oe_o);

    // R6: the data line is quiet outside the slot.
    p_quiet_line_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tx_oe_o |-> !tx_data_o);

    // R10: power-save idles both paths from the next cycle.
    p_save_idles_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pwr_save_o |=> (!rx_valid_o && !tx_oe_o));

endmodule

bind pcm_voice_port pcm_voice_port_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_sample_o(rx_sample_o),
    .rx_valid_o(rx_valid_o), .tx_data_o(tx_data_o), .tx_oe_o(tx_oe_o),
    .pwr_save_o(pwr_save_o)
);

// File: tb/pcm_voice_port_tb_top.sv
// Bench: behavioural cycle model compared every clock, plus directed checks.
module pcm_voice_port_tb_top;
    localparam int W    = 8;
    localparam int LB   = 32;
    localparam int LS   = 400;
    localparam int HALF = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic bclk = 1'b0, rxs = 1'b0, txs = 1'b0, rxd = 1'b0;
    logic [W-1:0] tx_word = '0;
    logic [W-1:0] rx_sample;
    logic rx_valid, tx_data, tx_oe, pwr_save;

    always #2 clk = ~clk;

    pcm_voice_port #(.SAMPLE_W(W), .SYNC_STAGES(2), .BCLK_TIMEOUT(LB),
                     .FSYNC_TIMEOUT(LS)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .bclk_i(bclk), .rx_sync_i(rxs),
        .rx_data_i(rxd), .tx_sync_i(txs), .tx_sample_i(tx_word),
        .rx_sample_o(rx_sample), .rx_valid_o(rx_valid), .tx_data_o(tx_data),
        .tx_oe_o(tx_oe), .pwr_save_o(pwr_save)
    );

    int checks = 0, errors = 0, nvalid = 0;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference (R11 latency: 3 edges) ----------
    bit [2:0] mb, mr, mt, md;
    int cb, cs, rx_n, tx_n;
    bit rx_act, tx_act, m_valid;
    bit [7:0] rx_byte, m_sample, tx_w;
    bit m_oe, m_txd, m_pwr;

    always @(posedge clk) begin
        bit br, bf, rr, tr, pwr;
        if (!rst_n) begin
            mb = 0; mr = 0; mt = 0; md = 0; cb = 0; cs = 0;
            rx_act = 0; tx_act = 0; rx_n = 0; tx_n = 0; rx_byte = 0;
            m_sample = 0; m_valid = 0; tx_w = 0;
        end else begin
            br = mb[1] && !mb[2]; bf = !mb[1] && mb[2];
            rr = mr[1] && !mr[2]; tr = mt[1] && !mt[2];
            pwr = (cb == LB) || (cs == LS);
            if (br || bf) cb = 0; else if (cb < LB) cb++;
            if (mt[1] != mt[2]) cs = 0; else if (cs < LS) cs++;
            m_valid = 0;
            if (pwr) rx_act = 0;
            else if (rr) begin rx_act = 1; rx_n = 0; end
            else if (bf && rx_act) begin
                rx_byte = {rx_byte[6:0], md[1]};
                rx_n++;
                if (rx_n == 8) begin m_sample = rx_byte; m_valid = 1; rx_act = 0; end
            end
            if (pwr) tx_act = 0;
            else if (tr) begin tx_w = tx_word; tx_n = 0; tx_act = 1; end
            else if (br && tx_act) begin
                if (tx_n == 7) tx_act = 0; else tx_n++;
            end
            mb = {mb[1:0], bclk}; mr = {mr[1:0], rxs};
            mt = {mt[1:0], txs}; md = {md[1:0], rxd};
        end
        m_oe  = tx_act;
        m_txd = tx_act ? tx_w[7-tx_n] : 1'b0;
        m_pwr = (cb == LB) || (cs == LS);
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(rx_valid == m_valid, "R2 R11 rx_valid_o", rx_valid, m_valid);
            check(rx_sample == m_sample, "R3 R11 rx_sample_o", rx_sample, m_sample);
            check(tx_oe == m_oe, "R5 R11 tx_oe_o", tx_oe, m_oe);
            check(tx_data == m_txd, "R5 R6 tx_data_o", tx_data, m_txd);
            check(pwr_save == m_pwr, "R7 R8 pwr_save_o", pwr_save, m_pwr);
            if (rx_valid) nvalid++;
        end
    end

    // ---------------- stimulus helpers ------------------------------------
    logic [31:0] txv, oev;

    // One frame of nb bit periods; masks and data indexed MSB first by period.
    task automatic frame(input logic [31:0] rs_m, input logic [31:0] rd,
                         input logic [31:0] ts_m, input int nb, input int swap_at);
        txv = '0; oev = '0;
        for (int i = 0; i < nb; i++) begin
            @(negedge clk);
            bclk = 1'b1; rxs = rs_m[31-i]; txs = ts_m[31-i]; rxd = rd[31-i];
            if (i == swap_at) tx_word = ~tx_word;
            repeat (HALF-1) @(negedge clk);
            txv[31-i] = tx_data; oev[31-i] = tx_oe;
            @(negedge clk);
            bclk = 1'b0;
            repeat (HALF-1) @(negedge clk);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        int v0;
        repeat (6) @(negedge clk);
        // R1: reset values
        check(rx_sample == 0 && !rx_valid, "R1 rx outputs", {rx_valid, rx_sample}, 0);
        check(!tx_oe && !tx_data && !pwr_save, "R1 tx/pwr outputs", {tx_oe, tx_data, pwr_save}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(rx_sample == 0 && !tx_oe && !pwr_save, "R1 after release",
              {rx_sample, tx_oe, pwr_save}, 0);

        // F1: rx 0xA5 at period 0 with trailing noise, tx 0x96 at period 8
        tx_word = 8'h96; v0 = nvalid;
        frame(32'h8000_0000, 32'hA5FF_3C0F, 32'h0080_0000, 32, -1);
        repeat (4) @(negedge clk);
        check(rx_sample == 8'hA5, "R2 rx byte", rx_sample, 8'hA5);
        check(nvalid - v0 == 1, "R12 one strobe despite extra bits", nvalid - v0, 1);
        check(txv[23:16] == 8'h96, "R5 tx bits", txv[23:16], 8'h96);
        check(oev[23:16] == 8'hFF && oev[15] == 1'b0, "R5 slot length", oev[23:15], 9'h1FE);
        check(oev[31:24] == 8'h00 && txv[31:24] == 8'h00, "R6 idle line before slot",
              {oev[31:24], txv[31:24]}, 0);

        // F2: rx 0x3C at period 3, tx 0x5A at period 0, word flipped mid slot
        tx_word = 8'h5A; v0 = nvalid;
        frame(32'h1000_0000, 32'h3C << 21, 32'h8000_0000, 32, 2);
        repeat (4) @(negedge clk);
        check(rx_sample == 8'h3C, "R2 rx byte offset frame", rx_sample, 8'h3C);
        check(txv[31:24] == 8'h5A, "R13 tx word held at sync", txv[31:24], 8'h5A);

        // F3: early second rx sync at period 4 drops the partial byte
        tx_word = 8'h00; v0 = nvalid;
        frame(32'h8800_0000, 32'hF000_0000 | (32'hC3 << 20), 32'h8000_0000, 32, -1);
        repeat (4) @(negedge clk);
        check(nvalid - v0 == 1, "R4 partial frame dropped", nvalid - v0, 1);
        check(rx_sample == 8'hC3, "R4 restarted byte", rx_sample, 8'hC3);

        // Bit clock stopped low for longer than its limit
        repeat (LB + 20) @(negedge clk);
        check(pwr_save == 1'b1, "R7 stopped bit clock", pwr_save, 1);

        // F5: wake frame; sync edges during power-save are ignored
        tx_word = 8'hFF; v0 = nvalid;
        frame(32'h8000_0000, 32'hAA00_0000, 32'h8000_0000, 32, -1);
        repeat (4) @(negedge clk);
        check(pwr_save == 1'b0, "R9 cleared by bit clock edge", pwr_save, 0);
        check(nvalid - v0 == 0, "R10 rx sync ignored in power-save", nvalid - v0, 0);
        check(oev == 32'h0, "R10 tx sync ignored in power-save", oev, 0);

        // F6: normal operation after wake
        tx_word = 8'h81;
        frame(32'h8000_0000, 32'hE700_0000, 32'h8000_0000, 32, -1);
        repeat (4) @(negedge clk);
        check(rx_sample == 8'hE7, "R9 rx after wake", rx_sample, 8'hE7);
        check(txv[31:24] == 8'h81, "R9 tx after wake", txv[31:24], 8'h81);

        // F7, F8: transmit sync stopped while bit clock runs
        frame(32'h8000_0000, 32'h1200_0000, 32'h0, 32, -1);
        v0 = nvalid;
        frame(32'h8000_0000, 32'h3400_0000, 32'h0, 32, -1);
        repeat (4) @(negedge clk);
        check(pwr_save == 1'b1, "R8 stopped transmit sync", pwr_save, 1);
        check(nvalid - v0 == 0, "R10 no strobe in power-save", nvalid - v0, 0);

        // F9: tx sync edge at period 2 clears, rx at period 4 frames again
        tx_word = 8'h55; v0 = nvalid;
        frame(32'h0800_0000, 32'h6B << 20, 32'h2000_0000, 32, -1);
        repeat (4) @(negedge clk);
        check(pwr_save == 1'b0, "R9 cleared by transmit sync edge", pwr_save, 0);
        check(nvalid - v0 == 1 && rx_sample == 8'h6B, "R9 rx resumes", rx_sample, 8'h6B);
        check(oev == 32'h0, "R10 waking sync edge not used", oev, 0);

        repeat (8) @(negedge clk);
        finish_run();
    end

endmodule